// File: doc/BRIEF.md
# Two-Line Prioritizing Interrupt Controller

This block collects a wide vector of level-sensitive request lines and presents them to a processor on two active-low lines: a fast line and a normal line. For every source, software chooses a priority, an enable, the line it is routed to, and whether it counts as secure. Two separate minimum-finding trees run side by side, one per line. Each tree picks the most urgent pending source in its group. The winning identifier of each group can be read back over the same register port used for configuration.

A global secure mask can be set through a register. While it is set, every source flagged secure is removed from both groups. A request is not latched. It counts only while its line is high, and it disappears from the result once the line falls. Resolution is pipelined. The enables are applied and the requests qualified into one register stage, and the trees feed a second register stage. Each output line and its identifier therefore change together, two clock edges after the request is sampled.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all source configuration words and the secure mask read 0, both output lines are high, and both identifiers read the all-ones "none" code (63 when N_SRC is 32).
- R2: A request is pending only while its line is high; when the line falls, the request leaves the result and is not held.
- R3: The register at address k, for k below N_SRC, holds source k's configuration: bits [3:0] are the priority, bit 4 routes the source to the fast line when 1 and to the normal line when 0, bit 5 is the enable, and bit 6 is the secure flag. Write data above bit 6 is discarded and reads back as 0.
- R4: A source whose enable bit is 0 never drives either line, whatever its request.
- R5: A source routed to the fast line can only win the fast group, and a source routed to the normal line can only win the normal group.
- R6: Within a group, the pending source with the numerically lowest priority value wins.
- R7: When pending sources in a group share the lowest priority value, the source with the lower index wins.
- R8: The two groups are sorted independently, so each line shows its own winner in the same cycle.
- R9: Bit 0 at address N_SRC+2 is the secure mask. While it is 1, sources with the secure flag are excluded from both groups. While it is 0, they take part normally.
- R10: When a group has no eligible pending source, its line stays high and its identifier is the all-ones code.
- R11: A request change sampled at a clock edge appears on the line and the identifier together at the second following edge, and not at the first.
- R12: Address N_SRC reads the fast identifier and N_SRC+1 reads the normal identifier. Writes to these two addresses have no effect, and any other address above N_SRC+2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Level-sensitive request lines |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | $clog2(N_SRC+3) | Register address |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Register read data, combinational from address |
| fiq_no | output | 1 | Fast interrupt line, active low |
| irq_no | output | 1 | Normal interrupt line, active low |
| fiq_id_o | output | $clog2(N_SRC+1) | Winning fast source, all ones when none |
| irq_id_o | output | $clog2(N_SRC+1) | Winning normal source, all ones when none |

## Verification
The assertions compare each reported winner with the request vector as it stood two samples earlier. They therefore assume that the request lines are synchronous to clk_i and are sampled cleanly at every edge. The bench drives them only on falling edges, so every request and write settles half a period before the rising edge that captures it. The assertions also assume that configuration changes only through the write strobe. The bench changes configuration only while the request vector is stable, and it waits out the full pipeline latency before it compares any result.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int PRIO_W = 4;

  typedef struct packed {
    logic              sec;
    logic              en;
    logic              fast;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int ID_W   = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [ID_W-1:0]         fiq_id_i,
  input  logic [ID_W-1:0]         irq_id_i,
  output src_cfg_t [N_SRC-1:0]    cfg_o,
  output logic                    sec_mask_o,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int CFG_W = $bits(src_cfg_t);
  localparam logic [ADDR_W-1:0] A_FIQ  = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(N_SRC + 1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(N_SRC + 2);

  src_cfg_t [N_SRC-1:0] cfg_q;
  logic                 mask_q;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) cfg_q[g] <= src_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= 1'b0;
    else if (we_i && addr_i == A_MASK) mask_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_SRC; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = DATA_W'(cfg_q[k]);
    if (addr_i == A_FIQ)  rdata_o = DATA_W'(fiq_id_i);
    if (addr_i == A_IRQ)  rdata_o = DATA_W'(irq_id_i);
    if (addr_i == A_MASK) rdata_o = DATA_W'(mask_q);
  end

  assign cfg_o      = cfg_q;
  assign sec_mask_o = mask_q;

  // R3: configuration only moves on a write strobe
  a_r3_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(cfg_q) && $stable(mask_q)));

  // R9: mask bit follows the write
  a_r9_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MASK) |=> (mask_q == $past(wdata_i[0])));
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int ID_W  = 6
) (
  input  logic [N_SRC-1:0]        vld_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    vld_o,
  output logic [ID_W-1:0]         id_o
);
  localparam int LEAVES = 2 ** $clog2(N_SRC);
  localparam int NODES  = 2 * LEAVES;

  logic              nd_vld  [NODES];
  logic [PRIO_W-1:0] nd_prio [NODES];
  logic [ID_W-1:0]   nd_id   [NODES];

  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      nd_vld[n]  = 1'b0;
      nd_prio[n] = '0;
      nd_id[n]   = '0;
    end
    for (int k = 0; k < N_SRC; k++) begin
      nd_vld[LEAVES+k]  = vld_i[k];
      nd_prio[LEAVES+k] = prio_i[k*PRIO_W +: PRIO_W];
      nd_id[LEAVES+k]   = ID_W'(k);
    end
    // left child holds lower indices, so it keeps ties
    for (int n = LEAVES - 1; n >= 1; n--) begin
      if (nd_vld[2*n] && (!nd_vld[2*n+1] || nd_prio[2*n] <= nd_prio[2*n+1])) begin
        nd_vld[n]  = 1'b1;
        nd_prio[n] = nd_prio[2*n];
        nd_id[n]   = nd_id[2*n];
      end else begin
        nd_vld[n]  = nd_vld[2*n+1];
        nd_prio[n] = nd_prio[2*n+1];
        nd_id[n]   = nd_id[2*n+1];
      end
    end
  end

  assign vld_o = nd_vld[1];
  assign id_o  = nd_id[1];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(N_SRC + 3),
  localparam int ID_W   = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              fiq_no,
  output logic              irq_no,
  output logic [ID_W-1:0]   fiq_id_o,
  output logic [ID_W-1:0]   irq_id_o
);
  localparam logic [ID_W-1:0] ID_NONE = '1;

  src_cfg_t [N_SRC-1:0]    cfg;
  logic                    sec_mask;
  logic [N_SRC-1:0]        fast_vld_q, norm_vld_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic                    fast_win, norm_win;
  logic [ID_W-1:0]         fast_id, norm_id;
  logic                    fiq_n_q, irq_n_q;
  logic [ID_W-1:0]         fiq_id_q, irq_id_q;

  irq_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .fiq_id_i(fiq_id_q), .irq_id_i(irq_id_q),
    .cfg_o(cfg), .sec_mask_o(sec_mask), .rdata_o(cfg_rdata_o)
  );

  // stage 1: qualify and steer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_vld_q <= '0;
      norm_vld_q <= '0;
      prio_q     <= '0;
    end else begin
      for (int k = 0; k < N_SRC; k++) begin
        fast_vld_q[k] <= req_i[k] && cfg[k].en && !(cfg[k].sec && sec_mask) &&  cfg[k].fast;
        norm_vld_q[k] <= req_i[k] && cfg[k].en && !(cfg[k].sec && sec_mask) && !cfg[k].fast;
        prio_q[k*PRIO_W +: PRIO_W] <= cfg[k].prio;
      end
    end
  end

  irq_prio_tree #(.N_SRC(N_SRC), .ID_W(ID_W)) u_fast_tree (
    .vld_i(fast_vld_q), .prio_i(prio_q), .vld_o(fast_win), .id_o(fast_id)
  );

  irq_prio_tree #(.N_SRC(N_SRC), .ID_W(ID_W)) u_norm_tree (
    .vld_i(norm_vld_q), .prio_i(prio_q), .vld_o(norm_win), .id_o(norm_id)
  );

  // stage 2: lines and IDs move together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_n_q  <= 1'b1;
      irq_n_q  <= 1'b1;
      fiq_id_q <= ID_NONE;
      irq_id_q <= ID_NONE;
    end else begin
      fiq_n_q  <= !fast_win;
      irq_n_q  <= !norm_win;
      fiq_id_q <= fast_win ? fast_id : ID_NONE;
      irq_id_q <= norm_win ? norm_id : ID_NONE;
    end
  end

  assign fiq_no   = fiq_n_q;
  assign irq_no   = irq_n_q;
  assign fiq_id_o = fiq_id_q;
  assign irq_id_o = irq_id_q;

  // R2: no raised line two samples back means both lines idle
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i, 2) == '0) |-> (fiq_no && irq_no));

  // R11: a reported winner had its request raised at the matching sample
  a_r11_fiq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_id_o != ID_NONE) |-> (|($past(req_i, 2) & (N_SRC'(1) << fiq_id_o))));

  a_r11_irq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_id_o != ID_NONE) |-> (|($past(req_i, 2) & (N_SRC'(1) << irq_id_o))));

  // R5: one source never wins both groups
  a_r5_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_id_o != ID_NONE && irq_id_o != ID_NONE) |-> (fiq_id_o != irq_id_o));

  // R10: identifiers stay in range or none
  a_r10_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_id_o == ID_NONE || int'(fiq_id_o) < N_SRC) && (irq_id_o == ID_NONE || int'(irq_id_o) < N_SRC));
endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  localparam int N_SRC = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = $clog2(N_SRC + 3);
  localparam int ID_W = $clog2(N_SRC + 1);
  localparam int NONE = 63;
  localparam int NV = 12;

  localparam logic [31:0] V_REQ [NV] = '{32'h0, 32'h1, 32'h2, 32'h7, 32'h14, 32'h11,
                                         32'h20, 32'h4A, 32'hA, 32'h8000_0000,
                                         32'h8000_00A0, 32'hFFFF_FFFF};
  localparam int V_FIQ [NV] = '{63, 0, 63, 2, 2, 4, 63, 63, 63, 31, 31, 2};
  localparam int V_IRQ [NV] = '{63, 63, 1, 1, 63, 63, 63, 6, 3, 63, 7, 6};
  localparam string V_TAG [NV] = '{"R10", "R5", "R5", "R8", "R7", "R7", "R4", "R6",
                                   "R6", "R5", "R8", "R6"};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_SRC-1:0]  req = '0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              fiq_n, irq_n;
  logic [ID_W-1:0]   fiq_id, irq_id;
  int n_chk = 0;
  int n_fail = 0;
  logic [DATA_W-1:0] rv;

  always #2 clk = ~clk;

  irq_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .fiq_no(fiq_n), .irq_no(irq_n), .fiq_id_o(fiq_id), .irq_id_o(irq_id)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input int ef, input int ei);
    check(tag, int'(fiq_id), ef);
    check(tag, int'(irq_id), ei);
    check(tag, int'(fiq_n), int'(ef == NONE));
    check(tag, int'(irq_n), int'(ei == NONE));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic drive(input logic [31:0] r);
    @(negedge clk);
    req = r;
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: reset state
    #1;
    check("R1", int'(fiq_n), 1);
    check("R1", int'(irq_n), 1);
    check("R1", int'(fiq_id), NONE);
    check("R1", int'(irq_id), NONE);
    rd(0, rv);  check("R1", int'(rv), 0);
    rd(34, rv); check("R1", int'(rv), 0);
    rd(32, rv); check("R1", int'(rv), NONE);

    // configuration: [3:0] prio, [4] fast, [5] en, [6] sec
    wr(0, 16'hFF35);
    wr(1, 16'h0025);
    wr(2, 16'h0032);
    wr(3, 16'h0062);
    wr(4, 16'h0032);
    wr(5, 16'h0010);
    wr(6, 16'h0021);
    wr(7, 16'h0069);
    wr(31, 16'h003F);
    rd(0, rv); check("R3", int'(rv), 'h35);
    rd(3, rv); check("R3", int'(rv), 'h62);
    rd(5, rv); check("R3", int'(rv), 'h10);
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(V_REQ[i]);
      check_out(V_TAG[i], V_FIQ[i], V_IRQ[i]);
    end

    // R11: latency of two edges, line and id together
    drive(32'h0);
    @(negedge clk) req = 32'h1;
    @(posedge clk); #1;
    check("R11", int'(fiq_n), 1);
    check("R11", int'(fiq_id), NONE);
    @(posedge clk); #1;
    check("R11", int'(fiq_n), 0);
    check("R11", int'(fiq_id), 0);

    // R2: dropping the line clears it, no latching
    drive(32'h0);
    check_out("R2", NONE, NONE);
    drive(32'h0);
    check_out("R2", NONE, NONE);

    // R9: secure mask
    wr(34, 1);
    rd(34, rv); check("R9", int'(rv), 1);
    drive(32'hA);  check_out("R9", NONE, 1);
    drive(32'h88); check_out("R9", NONE, NONE);
    drive(32'hD);  check_out("R9", 2, NONE);
    wr(34, 0);
    drive(32'h88); check_out("R9", NONE, 3);

    // R12: status reads, writes to them ignored, unmapped reads zero
    rd(32, rv); check("R12", int'(rv), NONE);
    rd(33, rv); check("R12", int'(rv), 3);
    wr(33, 0);
    wr(32, 5);
    rd(33, rv); check("R12", int'(rv), 3);
    rd(32, rv); check("R12", int'(rv), NONE);
    check_out("R12", NONE, 3);
    rd(40, rv); check("R12", int'(rv), 0);

    // R5: re-route source 0 to the normal line; R7 tie with source 1
    wr(0, 16'h0025);
    drive(32'h1); check_out("R5", NONE, 0);
    drive(32'h3); check_out("R7", NONE, 0);
    drive(32'h2); check_out("R7", NONE, 1);

    // R4: disable source 2
    wr(2, 16'h0012);
    drive(32'h4); check_out("R4", NONE, NONE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule